// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block moves a small processor core into a low-power state and back out. Software sets a sleep-enable bit and a 3-bit mode code, then the core pulses a sleep strobe. If the request is accepted, the controller holds the core halted and gates the clock domains (CPU, flash, I/O, ADC) and the main oscillator according to the chosen mode. While asleep, it qualifies incoming wake requests against what that mode permits. It then applies the mode's wake latency before it lets the core run again.

There are three wake latencies. Shallow modes go straight to a fixed halt of four cycles. The two oscillator-kept modes wait a fixed six-cycle start-up first. The two oscillator-off modes wait a start-up of programmable length first. A reset request during any non-running phase ends the sequence at once and signals a restart from the reset vector instead of a resume. All pins are plain control and status lines; no data stream crosses the block's edge, so there is no valid/ready handshake.

Mode codes: 000 Idle, 001 ADC-quiet, 010 Deep-off, 011 Deep-timer, 110 Standby-off, 111 Standby-timer; 100 and 101 are reserved. Clock-enable vectors below are written as {cpu, flash, io, adc, osc}.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: While running, a sleep strobe is acted on only if sleep_en is 1 in that same cycle. Otherwise cpu_halt stays 0 and all five enables stay 1.
- R2: In Idle (000) the enables are 00111 and cpu_halt is 1.
- R3: In ADC-quiet (001) the enables are 00011.
- R4: In Deep-off (010) and Deep-timer (011) the enables are 00000. In Standby-off (110) and Standby-timer (111) they are 00001.
- R5: A strobe with code 100 or 101 leaves the core running with all enables at 1 and sets mode_err. mode_err clears on the next accepted sleep entry.
- R6: An external line wakes the core in Idle whatever its configuration. In every other mode it wakes the core only when its ext_level bit is 1. Pin-change, address-match and watchdog requests wake the core in every mode.
- R7: A timer-2 event wakes the core only when its own enable and gie are both 1, and only in Idle, ADC-quiet, Deep-timer or Standby-timer.
- R8: adc_done and spm_ready wake the core only in Idle and ADC-quiet. other_io_req wakes it only in Idle.
- R9: If a wake is sampled at edge E in Idle or ADC-quiet, cpu_halt stays 1 with all enables 1 for four cycles. resume_pulse is then 1 for one cycle after edge E+4, when cpu_halt falls.
- R10: In Deep-off or Deep-timer with start-up count N, the enables are 00001 for N cycles, followed by four halted cycles with all enables 1. resume_pulse follows edge E+N+4. If N is 0, the controller goes straight to the halt phase.
- R11: In Standby-off or Standby-timer, resume_pulse follows edge E+10: six start-up cycles at 00001, then four halted cycles.
- R12: If reset_req is 1 at an edge while not running, restart_pulse is 1 and cpu_halt is 0 right after that edge, with all enables 1. No resume_pulse follows.
- R13: If the strobe meets a wake request that qualifies for the requested mode in the same cycle, sleep is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_en | input | 1 | Sleep permission bit |
| mode_sel | input | 3 | Requested sleep mode code |
| sleep_strobe | input | 1 | Sleep instruction pulse |
| reset_req | input | 1 | Reset request that ends sleep |
| startup_cycles | input | CNT_W | Oscillator start-up length for the deep modes |
| ext_req | input | N_EXT | External interrupt requests |
| ext_level | input | N_EXT | 1 = line configured level-sensitive |
| pcint_req | input | 1 | Pin-change request |
| twi_match | input | 1 | Serial address match |
| wdt_req | input | 1 | Watchdog request |
| t2_ovf | input | 1 | Timer-2 overflow event |
| t2_cmp | input | 1 | Timer-2 compare event |
| t2_ovf_ie | input | 1 | Overflow interrupt enable |
| t2_cmp_ie | input | 1 | Compare interrupt enable |
| gie | input | 1 | Global interrupt enable |
| adc_done | input | 1 | ADC conversion complete |
| spm_ready | input | 1 | Store/EEPROM ready |
| other_io_req | input | 1 | Any other peripheral request |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| osc_run | output | 1 | Main oscillator run enable |
| cpu_halt | output | 1 | Core halted |
| resume_pulse | output | 1 | One-cycle interrupt resume |
| restart_pulse | output | 1 | One-cycle restart from reset vector |
| mode_err | output | 1 | Reserved mode code was requested |

## Verification
Gating changes appear one cycle after the strobe edge, and restart appears one cycle after the reset request is sampled. A resume is due 4, N+4 or 10 cycles after the edge that samples the wake, depending on the mode's class. The stimulus task logs the cycle of every wake or reset request and pushes the cycle at which the pulse must appear onto a queue. A monitor that samples on the falling clock edge pops an entry at every resume or restart pulse and compares both the cycle and the pulse kind. Enable vectors are checked on the falling edge in the exact start-up and halt cycles, and masked wakes are checked by showing the enables unchanged a few cycles later.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [2:0] {
    SM_IDLE  = 3'b000,
    SM_ADCQ  = 3'b001,
    SM_DOFF  = 3'b010,
    SM_DTMR  = 3'b011,
    SM_RSV4  = 3'b100,
    SM_RSV5  = 3'b101,
    SM_SOFF  = 3'b110,
    SM_STMR  = 3'b111
  } slp_mode_e;

  typedef enum logic [1:0] {
    LAT_NONE  = 2'd0,
    LAT_PROG  = 2'd1,
    LAT_FIXED = 2'd2
  } wake_lat_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_START = 2'd2,
    ST_HALT  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic osc;
  } clk_prof_t;

  typedef struct packed {
    logic ext;
    logic ext_edge_ok;
    logic pcint;
    logic twi;
    logic wdt;
    logic t2;
    logic adc;
    logic spm;
    logic other;
  } wake_allow_t;

endpackage

// File: rtl/slp_mode_map.sv
module slp_mode_map
  import sleep_pkg::*;
(
  input  logic [2:0]  code,
  output clk_prof_t   prof,
  output wake_allow_t allow,
  output wake_lat_e   lat,
  output logic        reserved
);

  always_comb begin
    prof     = '1;
    allow    = '0;
    lat      = LAT_NONE;
    reserved = 1'b0;
    case (code)
      SM_IDLE: begin
        prof  = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
        allow = '1;
      end
      SM_ADCQ: begin
        prof  = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b1, osc: 1'b1};
        allow = '{ext: 1'b1, ext_edge_ok: 1'b0, pcint: 1'b1, twi: 1'b1,
                  wdt: 1'b1, t2: 1'b1, adc: 1'b1, spm: 1'b1, other: 1'b0};
      end
      SM_DOFF, SM_SOFF: begin
        prof  = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0,
                  osc: (code == SM_SOFF)};
        allow = '{ext: 1'b1, ext_edge_ok: 1'b0, pcint: 1'b1, twi: 1'b1,
                  wdt: 1'b1, t2: 1'b0, adc: 1'b0, spm: 1'b0, other: 1'b0};
        lat   = (code == SM_SOFF) ? LAT_FIXED : LAT_PROG;
      end
      SM_DTMR, SM_STMR: begin
        prof  = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0,
                  osc: (code == SM_STMR)};
        allow = '{ext: 1'b1, ext_edge_ok: 1'b0, pcint: 1'b1, twi: 1'b1,
                  wdt: 1'b1, t2: 1'b1, adc: 1'b0, spm: 1'b0, other: 1'b0};
        lat   = (code == SM_STMR) ? LAT_FIXED : LAT_PROG;
      end
      default: begin
        reserved = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/slp_wake_filter.sv
module slp_wake_filter
  import sleep_pkg::*;
#(
  parameter int N_EXT = 2
)(
  input  wake_allow_t      allow,
  input  logic [N_EXT-1:0] ext_req,
  input  logic [N_EXT-1:0] ext_level,
  input  logic             pcint_req,
  input  logic             twi_match,
  input  logic             wdt_req,
  input  logic             t2_ovf,
  input  logic             t2_cmp,
  input  logic             t2_ovf_ie,
  input  logic             t2_cmp_ie,
  input  logic             gie,
  input  logic             adc_done,
  input  logic             spm_ready,
  input  logic             other_io_req,
  output logic             hit
);

  logic [N_EXT-1:0] ext_hit;
  logic             t2_event;
  logic             misc_hit;

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    assign ext_hit[i] = ext_req[i] & allow.ext & (ext_level[i] | allow.ext_edge_ok);
  end

  assign t2_event = gie & ((t2_ovf & t2_ovf_ie) | (t2_cmp & t2_cmp_ie));

  assign misc_hit = (pcint_req    & allow.pcint) |
                    (twi_match    & allow.twi)   |
                    (wdt_req      & allow.wdt)   |
                    (t2_event     & allow.t2)    |
                    (adc_done     & allow.adc)   |
                    (spm_ready    & allow.spm)   |
                    (other_io_req & allow.other);

  assign hit = (|ext_hit) | misc_hit;

endmodule

// File: rtl/slp_sequencer.sv
module slp_sequencer
  import sleep_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int HALT_CYC = 4,
  parameter int STBY_CYC = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_strobe,
  input  logic             sleep_en,
  input  logic [2:0]       req_code,
  input  logic             req_reserved,
  input  logic             req_hit,
  input  logic             held_hit,
  input  wake_lat_e        held_lat,
  input  logic             reset_req,
  input  logic [CNT_W-1:0] startup_cycles,
  output seq_state_e       state,
  output logic [2:0]       held_code,
  output logic             resume_pulse,
  output logic             restart_pulse,
  output logic             mode_err
);

  localparam logic [CNT_W-1:0] HALT_LD = CNT_W'(HALT_CYC);
  localparam logic [CNT_W-1:0] STBY_LD = CNT_W'(STBY_CYC);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept = sleep_strobe & sleep_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_RUN;
      held_code     <= 3'b000;
      cnt           <= '0;
      resume_pulse  <= 1'b0;
      restart_pulse <= 1'b0;
      mode_err      <= 1'b0;
    end else begin
      resume_pulse  <= 1'b0;
      restart_pulse <= 1'b0;
      if (state != ST_RUN && reset_req) begin
        state         <= ST_RUN;
        restart_pulse <= 1'b1;
      end else begin
        case (state)
          ST_RUN: begin
            if (accept) begin
              if (req_reserved) begin
                mode_err <= 1'b1;
              end else if (!req_hit) begin
                state     <= ST_SLEEP;
                held_code <= req_code;
                mode_err  <= 1'b0;
              end
            end
          end
          ST_SLEEP: begin
            if (held_hit) begin
              case (held_lat)
                LAT_FIXED: begin
                  state <= ST_START;
                  cnt   <= STBY_LD;
                end
                LAT_PROG: begin
                  if (startup_cycles == '0) begin
                    state <= ST_HALT;
                    cnt   <= HALT_LD;
                  end else begin
                    state <= ST_START;
                    cnt   <= startup_cycles;
                  end
                end
                default: begin
                  state <= ST_HALT;
                  cnt   <= HALT_LD;
                end
              endcase
            end
          end
          ST_START: begin
            if (cnt <= ONE) begin
              state <= ST_HALT;
              cnt   <= HALT_LD;
            end else begin
              cnt <= cnt - ONE;
            end
          end
          ST_HALT: begin
            if (cnt <= ONE) begin
              state        <= ST_RUN;
              resume_pulse <= 1'b1;
            end else begin
              cnt <= cnt - ONE;
            end
          end
          default: state <= ST_RUN;
        endcase
      end
    end
  end

  p_reserved_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && accept && req_reserved) |=> (state == ST_RUN && mode_err));

  p_cancel_entry_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && accept && req_hit) |=> (state == ST_RUN));

  p_restart_now_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN && reset_req) |=> (state == ST_RUN && restart_pulse && !resume_pulse));

  p_resume_after_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> ($past(state) == ST_HALT));

endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl
  import sleep_pkg::*;
#(
  parameter int N_EXT    = 2,
  parameter int CNT_W    = 16,
  parameter int HALT_CYC = 4,
  parameter int STBY_CYC = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_en,
  input  logic [2:0]       mode_sel,
  input  logic             sleep_strobe,
  input  logic             reset_req,
  input  logic [CNT_W-1:0] startup_cycles,
  input  logic [N_EXT-1:0] ext_req,
  input  logic [N_EXT-1:0] ext_level,
  input  logic             pcint_req,
  input  logic             twi_match,
  input  logic             wdt_req,
  input  logic             t2_ovf,
  input  logic             t2_cmp,
  input  logic             t2_ovf_ie,
  input  logic             t2_cmp_ie,
  input  logic             gie,
  input  logic             adc_done,
  input  logic             spm_ready,
  input  logic             other_io_req,
  output logic             clk_en_cpu,
  output logic             clk_en_flash,
  output logic             clk_en_io,
  output logic             clk_en_adc,
  output logic             osc_run,
  output logic             cpu_halt,
  output logic             resume_pulse,
  output logic             restart_pulse,
  output logic             mode_err
);

  clk_prof_t   req_prof, held_prof, gate;
  wake_allow_t req_allow, held_allow;
  wake_lat_e   req_lat, held_lat;
  logic        req_reserved, held_reserved;
  logic        req_hit, held_hit;
  logic [2:0]  held_code;
  seq_state_e  state;

  slp_mode_map u_map_req (
    .code(mode_sel), .prof(req_prof), .allow(req_allow),
    .lat(req_lat), .reserved(req_reserved)
  );

  slp_mode_map u_map_held (
    .code(held_code), .prof(held_prof), .allow(held_allow),
    .lat(held_lat), .reserved(held_reserved)
  );

  slp_wake_filter #(.N_EXT(N_EXT)) u_filt_req (
    .allow(req_allow), .ext_req(ext_req), .ext_level(ext_level),
    .pcint_req(pcint_req), .twi_match(twi_match), .wdt_req(wdt_req),
    .t2_ovf(t2_ovf), .t2_cmp(t2_cmp), .t2_ovf_ie(t2_ovf_ie), .t2_cmp_ie(t2_cmp_ie),
    .gie(gie), .adc_done(adc_done), .spm_ready(spm_ready),
    .other_io_req(other_io_req), .hit(req_hit)
  );

  slp_wake_filter #(.N_EXT(N_EXT)) u_filt_held (
    .allow(held_allow), .ext_req(ext_req), .ext_level(ext_level),
    .pcint_req(pcint_req), .twi_match(twi_match), .wdt_req(wdt_req),
    .t2_ovf(t2_ovf), .t2_cmp(t2_cmp), .t2_ovf_ie(t2_ovf_ie), .t2_cmp_ie(t2_cmp_ie),
    .gie(gie), .adc_done(adc_done), .spm_ready(spm_ready),
    .other_io_req(other_io_req), .hit(held_hit)
  );

  slp_sequencer #(
    .CNT_W(CNT_W), .HALT_CYC(HALT_CYC), .STBY_CYC(STBY_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sleep_strobe(sleep_strobe), .sleep_en(sleep_en),
    .req_code(mode_sel), .req_reserved(req_reserved), .req_hit(req_hit),
    .held_hit(held_hit), .held_lat(held_lat),
    .reset_req(reset_req), .startup_cycles(startup_cycles),
    .state(state), .held_code(held_code),
    .resume_pulse(resume_pulse), .restart_pulse(restart_pulse),
    .mode_err(mode_err)
  );

  always_comb begin
    case (state)
      ST_SLEEP: gate = held_prof;
      ST_START: gate = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
      default:  gate = '1;
    endcase
  end

  assign clk_en_cpu   = gate.cpu;
  assign clk_en_flash = gate.flash;
  assign clk_en_io    = gate.io;
  assign clk_en_adc   = gate.adc;
  assign osc_run      = gate.osc;
  assign cpu_halt     = (state != ST_RUN);

  p_gated_cpu_halted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_cpu |-> cpu_halt);

  p_osc_off_all_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |-> (!clk_en_io && !clk_en_adc && !clk_en_cpu && cpu_halt));

endmodule

// File: tb/test_sleep_pwr_ctrl.sv
`timescale 1ns/1ps
module test_sleep_pwr_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sleep_en, sleep_strobe, reset_req;
  logic [2:0]  mode_sel;
  logic [15:0] startup_cycles;
  logic [1:0]  ext_req, ext_level;
  logic        pcint_req, twi_match, wdt_req, t2_ovf, t2_cmp, t2_ovf_ie, t2_cmp_ie, gie;
  logic        adc_done, spm_ready, other_io_req;
  logic        clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, osc_run;
  logic        cpu_halt, resume_pulse, restart_pulse, mode_err;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int    exp_kind[$];
  int    exp_cyc[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  sleep_pwr_ctrl i_sleep_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .mode_sel(mode_sel),
    .sleep_strobe(sleep_strobe), .reset_req(reset_req), .startup_cycles(startup_cycles),
    .ext_req(ext_req), .ext_level(ext_level), .pcint_req(pcint_req),
    .twi_match(twi_match), .wdt_req(wdt_req), .t2_ovf(t2_ovf), .t2_cmp(t2_cmp),
    .t2_ovf_ie(t2_ovf_ie), .t2_cmp_ie(t2_cmp_ie), .gie(gie), .adc_done(adc_done),
    .spm_ready(spm_ready), .other_io_req(other_io_req),
    .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash), .clk_en_io(clk_en_io),
    .clk_en_adc(clk_en_adc), .osc_run(osc_run), .cpu_halt(cpu_halt),
    .resume_pulse(resume_pulse), .restart_pulse(restart_pulse), .mode_err(mode_err)
  );

  function automatic logic [4:0] gates();
    return {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, osc_run};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter(input logic [2:0] m);
    mode_sel = m; sleep_en = 1'b1; sleep_strobe = 1'b1;
    tick(1);
    sleep_strobe = 1'b0; sleep_en = 1'b0;
  endtask

  // Driver side of the scoreboard: kind 0 = resume, 1 = restart
  task automatic expect_ev(input int kind, input int lat, input string tag);
    exp_kind.push_back(kind);
    exp_cyc.push_back(cyc + 1 + lat);
    exp_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && (resume_pulse === 1'b1 || restart_pulse === 1'b1)) begin
      if (exp_cyc.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected pulse: actual resume=%0b restart=%0b at %0d expected none",
                 resume_pulse, restart_pulse, cyc);
      end else begin
        automatic int    k = exp_kind.pop_front();
        automatic int    c = exp_cyc.pop_front();
        automatic string t = exp_tag.pop_front();
        check({t, " pulse kind"}, {30'd0, restart_pulse, resume_pulse}, (k == 1) ? 2 : 1);
        check({t, " pulse cycle"}, cyc, c);
      end
    end
  end

  initial begin
    rst_n = 1'b0; sleep_en = 0; sleep_strobe = 0; reset_req = 0; mode_sel = 3'b000;
    startup_cycles = 16'd10; ext_req = 0; ext_level = 0; pcint_req = 0; twi_match = 0;
    wdt_req = 0; t2_ovf = 0; t2_cmp = 0; t2_ovf_ie = 0; t2_cmp_ie = 0; gie = 0;
    adc_done = 0; spm_ready = 0; other_io_req = 0;
    tick(3); rst_n = 1'b1; tick(1);

    check("R1 reset gates", gates(), 5'b11111);
    check("R1 reset halt", cpu_halt, 0);
    check("R5 reset err", mode_err, 0);

    // R1: strobe without sleep_en is ignored
    mode_sel = 3'b000; sleep_strobe = 1'b1; tick(1); sleep_strobe = 1'b0;
    check("R1 no enable halt", cpu_halt, 0);
    check("R1 no enable gates", gates(), 5'b11111);

    // R2 idle gating, R6 edge line wakes idle, R9 latency
    enter(3'b000);
    check("R2 idle gates", gates(), 5'b00111);
    check("R2 idle halt", cpu_halt, 1);
    ext_req = 2'b01; expect_ev(0, 4, "R9 idle resume"); tick(1); ext_req = 0;
    check("R9 halt phase gates", gates(), 5'b11111);
    check("R9 halt phase halt", cpu_halt, 1);
    tick(5);
    check("R9 idle running", cpu_halt, 0);

    // R3 ADC-quiet gating, R6 edge masked, R8 other masked, level wakes
    enter(3'b001);
    check("R3 adcq gates", gates(), 5'b00011);
    ext_req = 2'b01; other_io_req = 1; tick(1); ext_req = 0; other_io_req = 0; tick(2);
    check("R6 R8 masked in adcq", gates(), 5'b00011);
    ext_level = 2'b10; ext_req = 2'b10; expect_ev(0, 4, "R6 level wake adcq");
    tick(1); ext_req = 0; ext_level = 0; tick(5);
    check("R6 adcq running", cpu_halt, 0);
    enter(3'b001);
    adc_done = 1; expect_ev(0, 4, "R8 adc wake"); tick(1); adc_done = 0; tick(5);

    // R4 deep-off, R7 timer masked, R10 programmable start-up
    enter(3'b010);
    check("R4 deep-off gates", gates(), 5'b00000);
    t2_ovf = 1; t2_ovf_ie = 1; gie = 1; adc_done = 1; tick(1); t2_ovf = 0; adc_done = 0; tick(2);
    check("R7 R8 masked in deep-off", gates(), 5'b00000);
    pcint_req = 1; expect_ev(0, 14, "R10 deep-off resume"); tick(1); pcint_req = 0;
    check("R10 start-up first", gates(), 5'b00001);
    tick(9);
    check("R10 start-up last", gates(), 5'b00001);
    tick(1);
    check("R10 halt phase", gates(), 5'b11111);
    check("R10 halt phase halt", cpu_halt, 1);
    tick(5);

    // R7 timer needs gie, deep-timer, N=3
    startup_cycles = 16'd3; gie = 0;
    enter(3'b011);
    check("R4 deep-timer gates", gates(), 5'b00000);
    t2_ovf = 1; tick(1); t2_ovf = 0; tick(2);
    check("R7 no gie masked", gates(), 5'b00000);
    gie = 1; t2_ovf = 1; expect_ev(0, 7, "R7 R10 timer wake"); tick(1); t2_ovf = 0; tick(8);
    check("R10 deep-timer running", cpu_halt, 0);

    // R10 zero start-up
    startup_cycles = 16'd0;
    enter(3'b010);
    twi_match = 1; expect_ev(0, 4, "R10 zero start-up"); tick(1); twi_match = 0;
    check("R10 zero start-up halt phase", gates(), 5'b11111);
    tick(5);

    // R4 standby-off, R11 fixed latency, R7 timer masked there
    enter(3'b110);
    check("R4 standby-off gates", gates(), 5'b00001);
    t2_ovf = 1; tick(1); t2_ovf = 0; tick(2);
    check("R7 masked in standby-off", gates(), 5'b00001);
    wdt_req = 1; expect_ev(0, 10, "R11 standby-off resume"); tick(1); wdt_req = 0;
    check("R11 start-up gates", gates(), 5'b00001);
    tick(11);
    check("R11 running", cpu_halt, 0);

    // R4 standby-timer, R11 + R7 compare wake
    enter(3'b111);
    check("R4 standby-timer gates", gates(), 5'b00001);
    t2_cmp = 1; t2_cmp_ie = 1; expect_ev(0, 10, "R11 R7 compare wake");
    tick(1); t2_cmp = 0; tick(11);

    // R5 reserved codes
    enter(3'b100);
    check("R5 rsv4 halt", cpu_halt, 0);
    check("R5 rsv4 gates", gates(), 5'b11111);
    check("R5 rsv4 err", mode_err, 1);
    enter(3'b101);
    check("R5 rsv5 halt", cpu_halt, 0);
    check("R5 rsv5 err", mode_err, 1);
    enter(3'b000);
    check("R5 err cleared", mode_err, 0);
    spm_ready = 1; expect_ev(0, 4, "R8 spm wake idle"); tick(1); spm_ready = 0; tick(5);

    // R12 reset during sleep and during start-up
    startup_cycles = 16'd20;
    enter(3'b010);
    reset_req = 1; expect_ev(1, 0, "R12 reset in sleep"); tick(1); reset_req = 0;
    check("R12 gates", gates(), 5'b11111);
    check("R12 halt", cpu_halt, 0);
    enter(3'b011);
    pcint_req = 1; tick(1); pcint_req = 0; tick(2);
    reset_req = 1; expect_ev(1, 0, "R12 reset in start-up"); tick(1); reset_req = 0;
    check("R12 start-up halt", cpu_halt, 0);
    tick(25);

    // R13 cancel on same-cycle qualified wake; unqualified one does not cancel
    startup_cycles = 16'd0;
    mode_sel = 3'b000; sleep_en = 1; sleep_strobe = 1; other_io_req = 1; tick(1);
    sleep_en = 0; sleep_strobe = 0; other_io_req = 0;
    check("R13 cancel halt", cpu_halt, 0);
    check("R13 cancel gates", gates(), 5'b11111);
    mode_sel = 3'b010; sleep_en = 1; sleep_strobe = 1; ext_req = 2'b01; tick(1);
    sleep_en = 0; sleep_strobe = 0; ext_req = 0;
    check("R13 unqualified enters", cpu_halt, 1);
    pcint_req = 1; expect_ev(0, 4, "R6 pin-change wake"); tick(1); pcint_req = 0; tick(5);

    tick(3);
    check("scoreboard drained", exp_cyc.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule